// File: doc/BRIEF.md
# Waveform Code Sequencer with Hold

This block turns a small set of shape settings into a stream of sample codes for a pulse-width or noise-shaping modulator placed after it. Four shapes are available: sine, rising ramp, falling ramp and triangle. Each of them spans from a programmed low code to a programmed high code and lasts a programmed number of samples. A sine is set by a phase increment per sample and a starting phase. It is read from a folded quarter-wave table.

Optional lead-in and tail intervals can wrap the waveform. The lead-in repeats the first code for a programmed count before the waveform starts, and the tail repeats the last code after it ends. This lets an external analog filter settle at the start level before a ramp, or stay at the end level afterwards. A single start pulse launches the whole lead-in, waveform and tail sequence. When the sequence ends, a done flag rises and the final code stays on the output.

Top module: `wavegen_seq`

## Requirements
- R1: A start pulse is accepted only while the block is idle or done, and it captures every setting at that edge. A start pulse or a setting change during a running sequence has no effect on the codes that follow.
- R2: When `lead_len` is nonzero, the stream begins with `lead_len` samples, each equal to waveform sample 0. When `lead_len` is zero, the stream begins directly with the waveform.
- R3: The waveform part holds exactly `n_samples` samples (n_samples ≥ 1), and the whole stream holds lead_len + n_samples + tail_len samples.
- R4: When `tail_len` is nonzero, the waveform is followed by `tail_len` samples, each equal to the last waveform sample.
- R5: For shape code 1 (rising ramp), sample n equals lo + floor(n·(hi−lo)/(N−1)), where N = n_samples. The first sample is therefore lo and the last is exactly hi. When N = 1, the single sample is lo.
- R6: For shape code 2 (falling ramp), sample n equals hi − floor(n·(hi−lo)/(N−1)). The first sample is hi and the last is exactly lo. When N = 1, the single sample is hi.
- R7: For shape code 3 (triangle), let K = floor((N−1)/2) and m = min(n, N−1−n). Sample n equals lo + floor(m·(hi−lo)/K), and equals lo when K = 0. The triangle rises to hi at n = K and falls back to lo at the last sample.
- R8: For shape code 0 (sine), the phase of sample n is p = (phase_init + n·phase_step) mod 2^16. The quadrant is q = p[15:14] and the index is i = p[13:9]. The folded address is a = 32−i when q is odd, else a = i. The table value is T(a) = floor(4096·x/(5120−x)) with x = a·(64−a), and the signed value s is −T(a) when q ≥ 2, else T(a). The sample equals lo + floor((hi−lo)·(s+1024)/2048).
- R9: A sample is transferred only on a cycle where `smp_valid` and `smp_ready` are both high. While `smp_ready` is low, `smp_valid` and `smp_code` stay unchanged.
- R10: After the last sample is transferred, `seq_done` is high and `smp_valid` is low, and `smp_code` keeps the last sample's value until the next accepted start.
- R11: After reset, `smp_valid` and `seq_done` are low and `smp_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a sequence when idle or done |
| shape_sel | input | 2 | 0 sine, 1 rising ramp, 2 falling ramp, 3 triangle |
| lo_code | input | CODE_W | Lowest code of the waveform |
| hi_code | input | CODE_W | Highest code of the waveform (≥ lo_code) |
| n_samples | input | CNT_W | Waveform length in samples |
| lead_len | input | CNT_W | Repeats of the first code before the waveform |
| tail_len | input | CNT_W | Repeats of the last code after the waveform |
| phase_init | input | PH_W | Sine starting phase |
| phase_step | input | PH_W | Sine phase increment per sample |
| smp_valid | output | 1 | Sample code available |
| smp_ready | input | 1 | Consumer accepts the sample |
| smp_code | output | CODE_W | Sample code |
| seq_done | output | 1 | Sequence finished, last code held |

## Verification
The bench runs every shape over lengths from 1 to 17 samples. These include the even and odd lengths that separate a triangle with a flat two-sample peak from one with a single peak. The lengths are crossed with zero, tiny, mid and full-scale code spans, where a bad quotient or remainder carry in the ramp stepper would show up as a missed endpoint. Sine runs use phase increments that cross quadrant boundaries and phase starts that fall in different quadrants, so that folding and sign errors can be told apart. Some runs throttle `smp_ready` and add a mid-run start with changed settings, to separate stall handling and setting capture from the shape arithmetic.

// File: rtl/wg_pkg.sv
// Package: shared encodings for the waveform code sequencer.
// Assumes: shape codes are visible at the top-level port and must stay fixed.
package wg_pkg;
    typedef enum logic [1:0] {
        SH_SINE = 2'd0,
        SH_UP   = 2'd1,
        SH_DOWN = 2'd2,
        SH_TRI  = 2'd3
    } shape_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_LEAD  = 3'd2,
        ST_MAIN  = 3'd3,
        ST_TAIL  = 3'd4,
        ST_DONE  = 3'd5
    } seq_st_e;
endpackage

// File: rtl/wg_divider.sv
// Module: sequential restoring divider, one quotient bit per cycle.
// Does: on go, divides num by den in NUM_W cycles; busy is high meanwhile.
// Assumes: den is nonzero when the result is used (caller masks den == 0).
module wg_divider #(
    parameter int NUM_W = 12,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic [NUM_W-1:0] quot,
    output logic [DEN_W-1:0] rem
);
    localparam int CW = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] num_sh;
    logic [NUM_W-1:0] num_r;
    logic [DEN_W-1:0] den_r;
    logic [CW-1:0]    cnt;
    logic [DEN_W:0]   trial;
    logic             take;

    // Trial subtraction of the next partial remainder.
    always_comb begin
        trial = {rem, num_sh[NUM_W-1]};
        take  = (trial >= {1'b0, den_r});
    end

    // Iteration registers: load on go, then shift one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_sh <= '0;
            num_r  <= '0;
            den_r  <= '0;
            cnt    <= '0;
            busy   <= 1'b0;
            quot   <= '0;
            rem    <= '0;
        end else if (go) begin
            num_sh <= num;
            num_r  <= num;
            den_r  <= den;
            cnt    <= CW'(NUM_W);
            busy   <= 1'b1;
            quot   <= '0;
            rem    <= '0;
        end else if (busy) begin
            num_sh <= num_sh << 1;
            quot   <= {quot[NUM_W-2:0], take};
            rem    <= take ? DEN_W'(trial - {1'b0, den_r}) : DEN_W'(trial);
            cnt    <= cnt - CW'(1);
            busy   <= (cnt != CW'(1));
        end
    end

    // R5: a finished division reconstructs the dividend with a remainder below the divisor.
    assert_div_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && den_r != '0) |->
            ((NUM_W+DEN_W)'(quot) * (NUM_W+DEN_W)'(den_r) + (NUM_W+DEN_W)'(rem)
                == (NUM_W+DEN_W)'(num_r)) && (rem < den_r));
endmodule

// File: rtl/wg_ramp_acc.sv
// Module: exact fractional stepper for ramps and triangles.
// Does: keeps acc = floor(m*span/d) as m moves by +1 or -1, using quotient
//       q = span/d and remainder r = span%d, with no per-step division.
// Assumes: inc and dec are never high together; r < d whenever d != 0.
module wg_ramp_acc #(
    parameter int VAL_W = 12,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    input  logic [VAL_W-1:0] q,
    input  logic [DEN_W-1:0] r,
    input  logic [DEN_W-1:0] d,
    output logic [VAL_W-1:0] acc
);
    logic [DEN_W-1:0] frac;
    logic [DEN_W:0]   up_sum;
    logic             up_carry;
    logic             dn_borrow;

    // Carry and borrow detection for the fractional part.
    always_comb begin
        up_sum    = {1'b0, frac} + {1'b0, r};
        up_carry  = (up_sum >= {1'b0, d});
        dn_borrow = (frac < r);
    end

    // Integer and fractional accumulator update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc  <= '0;
            frac <= '0;
        end else if (inc) begin
            acc  <= acc + q + VAL_W'(up_carry);
            frac <= up_carry ? DEN_W'(up_sum - {1'b0, d}) : DEN_W'(up_sum);
        end else if (dec) begin
            acc  <= acc - q - VAL_W'(dn_borrow);
            frac <= dn_borrow ? DEN_W'({1'b0, frac} + {1'b0, d} - {1'b0, r})
                              : frac - r;
        end
    end

    // R7: the fractional part stays below the divisor.
    assert_frac_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (d != '0 && !clr) |=> (frac < d || $changed(d)));
endmodule

// File: rtl/wg_sine_lut.sv
// Module: quarter-wave sine lookup with quadrant folding.
// Does: maps a phase word to a signed value in [-2^AMP_W, 2^AMP_W]; the
//       quarter table is computed at elaboration from a rational approximation.
// Assumes: PH_W - 2 >= LUT_AW; purely combinational.
module wg_sine_lut #(
    parameter int PH_W   = 16,
    parameter int LUT_AW = 5,
    parameter int AMP_W  = 10
) (
    input  logic [PH_W-1:0]         phase,
    output logic signed [AMP_W+1:0] sval
);
    localparam int NQ = 1 << LUT_AW;

    // Table entry for quarter index i: 4*H*x/(5*NQ^2 - x), x = i*(2*NQ - i).
    function automatic longint tab_val(input int i);
        longint x;
        x = longint'(i) * longint'(2 * NQ - i);
        return (longint'(4) * (longint'(1) << AMP_W) * x) /
               (longint'(5) * longint'(NQ) * longint'(NQ) - x);
    endfunction

    logic [AMP_W:0]    rom [0:NQ];
    logic [1:0]        quad;
    logic [LUT_AW-1:0] idx;
    logic [LUT_AW:0]   addr;
    logic [AMP_W:0]    mag;

    for (genvar g = 0; g <= NQ; g++) begin : g_rom
        assign rom[g] = (AMP_W+1)'(tab_val(g));
    end

    // Quadrant fold and sign selection.
    always_comb begin
        quad = phase[PH_W-1 -: 2];
        idx  = phase[PH_W-3 -: LUT_AW];
        addr = quad[0] ? ((LUT_AW+1)'(NQ) - {1'b0, idx}) : {1'b0, idx};
        mag  = rom[addr];
        sval = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end
endmodule

// File: rtl/wavegen_seq.sv
// Module: waveform code sequencer with lead-in and tail hold.
// Does: on start, captures the settings, computes the ramp step by a serial
//       division, then streams lead-in repeats of the first code, the
//       waveform, and tail repeats of the last code over valid/ready.
// Assumes: hi_code >= lo_code, n_samples >= 1; smp_code is derived from
//          registered state, so a transfer changes it one cycle later.
module wavegen_seq
    import wg_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int CNT_W  = 16,
    parameter int PH_W   = 16,
    parameter int LUT_AW = 5,
    parameter int AMP_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        shape_sel,
    input  logic [CODE_W-1:0] lo_code,
    input  logic [CODE_W-1:0] hi_code,
    input  logic [CNT_W-1:0]  n_samples,
    input  logic [CNT_W-1:0]  lead_len,
    input  logic [CNT_W-1:0]  tail_len,
    input  logic [PH_W-1:0]   phase_init,
    input  logic [PH_W-1:0]   phase_step,
    output logic              smp_valid,
    input  logic              smp_ready,
    output logic [CODE_W-1:0] smp_code,
    output logic              seq_done
);
    localparam int SV_W   = AMP_W + 2;
    localparam int PROD_W = CODE_W + SV_W;
    localparam logic [SV_W-1:0] SV_HALF = SV_W'(1) << AMP_W;

    seq_st_e          st;
    shape_e           shape_r;
    logic [CODE_W-1:0] lo_r, hi_r, span_r;
    logic [CNT_W-1:0]  ns_r, lead_r, tail_r, step_d;
    logic [PH_W-1:0]   step_r, phase_r;
    logic [CNT_W-1:0]  n_cnt, h_cnt, m_r;
    logic              accept, fire, last_main, advance;
    logic [CNT_W-1:0]  nm1_in, d_in, tri_tgt;
    logic              tri_up, tri_dn;
    logic              div_busy;
    logic [CODE_W-1:0] div_q, q_eff, acc;
    logic [CNT_W-1:0]  div_r, r_eff;
    logic signed [SV_W-1:0] sval;
    logic [SV_W-1:0]   sv_off;
    logic [PROD_W-1:0] prod;
    logic [CODE_W-1:0] code_c;

    // Start acceptance and divisor selection from the live inputs.
    always_comb begin
        accept = start && (st == ST_IDLE || st == ST_DONE);
        nm1_in = n_samples - CNT_W'(1);
        d_in   = (shape_e'(shape_sel) == SH_TRI) ? (nm1_in >> 1) : nm1_in;
    end

    wg_divider #(.NUM_W(CODE_W), .DEN_W(CNT_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (accept),
        .num  (hi_code - lo_code),
        .den  (d_in),
        .busy (div_busy),
        .quot (div_q),
        .rem  (div_r)
    );

    // Zero step when the divisor is zero (one-sample ramp, short triangle).
    always_comb begin
        q_eff = (step_d == '0) ? '0 : div_q;
        r_eff = (step_d == '0) ? '0 : div_r;
    end

    // Transfer, last-sample and triangle direction decisions.
    always_comb begin
        fire      = smp_valid && smp_ready;
        last_main = (n_cnt == ns_r - CNT_W'(1));
        advance   = fire && (st == ST_MAIN) && !last_main;
        tri_tgt   = ns_r - CNT_W'(2) - n_cnt;
        tri_up    = (n_cnt + CNT_W'(1)) <= step_d;
        tri_dn    = !tri_up && (tri_tgt < m_r);
    end

    wg_ramp_acc #(.VAL_W(CODE_W), .DEN_W(CNT_W)) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (accept),
        .inc  (advance && (shape_r == SH_UP || shape_r == SH_DOWN ||
                           (shape_r == SH_TRI && tri_up))),
        .dec  (advance && shape_r == SH_TRI && tri_dn),
        .q    (q_eff),
        .r    (r_eff),
        .d    (step_d),
        .acc  (acc)
    );

    wg_sine_lut #(.PH_W(PH_W), .LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_lut (
        .phase(phase_r),
        .sval (sval)
    );

    // Output code selection by shape.
    always_comb begin
        sv_off = $unsigned(sval) + SV_HALF;
        prod   = PROD_W'(span_r) * PROD_W'(sv_off);
        case (shape_r)
            SH_UP, SH_TRI: code_c = lo_r + acc;
            SH_DOWN:       code_c = hi_r - acc;
            default:       code_c = lo_r + CODE_W'(prod >> (AMP_W + 1));
        endcase
    end

    // Captured settings, loaded only on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shape_r <= SH_UP;
            lo_r    <= '0;
            hi_r    <= '0;
            span_r  <= '0;
            ns_r    <= '0;
            lead_r  <= '0;
            tail_r  <= '0;
            step_d  <= '0;
            step_r  <= '0;
        end else if (accept) begin
            shape_r <= shape_e'(shape_sel);
            lo_r    <= lo_code;
            hi_r    <= hi_code;
            span_r  <= hi_code - lo_code;
            ns_r    <= n_samples;
            lead_r  <= lead_len;
            tail_r  <= tail_len;
            step_d  <= d_in;
            step_r  <= phase_step;
        end
    end

    // Waveform position: sample index, triangle distance, sine phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_cnt   <= '0;
            m_r     <= '0;
            phase_r <= '0;
        end else if (accept) begin
            n_cnt   <= '0;
            m_r     <= '0;
            phase_r <= phase_init;
        end else if (advance) begin
            n_cnt   <= n_cnt + CNT_W'(1);
            phase_r <= phase_r + step_r;
            if (tri_up)
                m_r <= m_r + CNT_W'(1);
            else if (tri_dn)
                m_r <= m_r - CNT_W'(1);
        end
    end

    // Sequence control: setup, lead-in, waveform, tail, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            h_cnt <= '0;
        end else if (accept) begin
            st    <= ST_SETUP;
            h_cnt <= '0;
        end else begin
            case (st)
                ST_SETUP: if (!div_busy) st <= (lead_r != '0) ? ST_LEAD : ST_MAIN;
                ST_LEAD: if (fire) begin
                    if (h_cnt == lead_r - CNT_W'(1)) begin
                        st    <= ST_MAIN;
                        h_cnt <= '0;
                    end else begin
                        h_cnt <= h_cnt + CNT_W'(1);
                    end
                end
                ST_MAIN: if (fire && last_main)
                    st <= (tail_r != '0) ? ST_TAIL : ST_DONE;
                ST_TAIL: if (fire) begin
                    if (h_cnt == tail_r - CNT_W'(1))
                        st <= ST_DONE;
                    else
                        h_cnt <= h_cnt + CNT_W'(1);
                end
                default: st <= st;
            endcase
        end
    end

    assign smp_valid = (st == ST_LEAD) || (st == ST_MAIN) || (st == ST_TAIL);
    assign seq_done  = (st == ST_DONE);
    assign smp_code  = code_c;

    // R9: a stalled sample stays offered and unchanged.
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_code)));

    // R10: done never coexists with a valid sample.
    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !smp_valid);

    // R10: the last code holds while done and no start arrives.
    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !start) |=> $stable(smp_code));

    // R1: a start during a running sequence leaves the captured settings alone.
    assert_busy_start_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && start) |=> ($stable(lo_r) && $stable(hi_r) && $stable(shape_r)
                                  && $stable(ns_r)));

    // R8: every offered code lies within the captured span.
    assert_code_in_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> (smp_code >= lo_r && smp_code <= hi_r));

    // R5: a rising ramp starts on lo and ends exactly on hi.
    assert_rise_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MAIN && shape_r == SH_UP && ns_r > CNT_W'(1) && last_main)
            |-> smp_code == hi_r);

    // R6: a falling ramp ends exactly on lo.
    assert_fall_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MAIN && shape_r == SH_DOWN && ns_r > CNT_W'(1) && last_main)
            |-> smp_code == lo_r);

    // R7: a triangle reaches hi at its apex sample.
    assert_tri_apex_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MAIN && shape_r == SH_TRI && step_d != '0 && n_cnt == step_d)
            |-> smp_code == hi_r);
endmodule

// File: tb/sim_wavegen_seq.sv
// Bench: sweeps shapes, lengths, spans, lead/tail counts and stall patterns,
// comparing each transferred sample with an arithmetic model of the requirements.
module sim_wavegen_seq;
    localparam int CODE_W = 12;
    localparam int CNT_W  = 16;
    localparam int PH_W   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        shape_sel = '0;
    logic [CODE_W-1:0] lo_code = '0, hi_code = '0;
    logic [CNT_W-1:0]  n_samples = '0, lead_len = '0, tail_len = '0;
    logic [PH_W-1:0]   phase_init = '0, phase_step = '0;
    logic              smp_valid, smp_ready = 1'b0, seq_done;
    logic [CODE_W-1:0] smp_code;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wavegen_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .shape_sel(shape_sel),
        .lo_code(lo_code), .hi_code(hi_code), .n_samples(n_samples),
        .lead_len(lead_len), .tail_len(tail_len), .phase_init(phase_init),
        .phase_step(phase_step), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_code(smp_code), .seq_done(seq_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tab(input int a);
        int x;
        x = a * (64 - a);
        return (4096 * x) / (5120 - x);
    endfunction

    // Expected waveform sample n (R5, R6, R7, R8).
    function automatic int model(input int shp, input int lo, input int hi, input int ns,
                                 input int ph0, input int fw, input int n);
        int span, hd, m, ph, q, i, a, s;
        span = hi - lo;
        case (shp)
            1: return (ns > 1) ? lo + (n * span) / (ns - 1) : lo;
            2: return (ns > 1) ? hi - (n * span) / (ns - 1) : hi;
            3: begin
                hd = (ns - 1) / 2;
                m  = (n < ns - 1 - n) ? n : ns - 1 - n;
                return (hd == 0) ? lo : lo + (m * span) / hd;
            end
            default: begin
                ph = (ph0 + n * fw) & 32'hFFFF;
                q  = ph >> 14;
                i  = (ph >> 9) & 31;
                a  = (q % 2 == 1) ? 32 - i : i;
                s  = (q >= 2) ? -tab(a) : tab(a);
                return lo + (span * (s + 1024)) / 2048;
            end
        endcase
    endfunction

    task automatic run_case(input int shp, input int lo, input int hi, input int ns,
                            input int pre, input int post, input int ph0, input int fw,
                            input bit stall, input bit disturb);
        int total, idx, cyc, k, exp, held;
        bit have_hold, dd;
        string rq;
        @(negedge clk);
        shape_sel = 2'(shp); lo_code = CODE_W'(lo); hi_code = CODE_W'(hi);
        n_samples = CNT_W'(ns); lead_len = CNT_W'(pre); tail_len = CNT_W'(post);
        phase_init = PH_W'(ph0); phase_step = PH_W'(fw);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        total = pre + ns + post; idx = 0; cyc = 0; have_hold = 0; dd = 0; held = 0;
        rq = (shp == 0) ? "R8" : (shp == 1) ? "R5" : (shp == 2) ? "R6" : "R7";
        while (!seq_done && cyc < 3000) begin
            if (have_hold) chk(smp_valid && int'(smp_code) == held, "R9 stall", int'(smp_code), held);
            smp_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            if (disturb && !dd && idx == pre + 1) begin
                start = 1'b1; lo_code = hi_code; shape_sel = shape_sel ^ 2'd1;
                n_samples = CNT_W'(3); dd = 1;
            end else begin
                start = 1'b0;
            end
            have_hold = 0;
            if (smp_valid) begin
                if (smp_ready) begin
                    k = (idx < pre) ? 0 : (idx < pre + ns) ? idx - pre : ns - 1;
                    exp = model(shp, lo, hi, ns, ph0, fw, k);
                    if (idx >= total) chk(0, "R3 overrun", idx, total);
                    else if (idx < pre) chk(int'(smp_code) == exp, "R2 lead", int'(smp_code), exp);
                    else if (idx >= pre + ns) chk(int'(smp_code) == exp, "R4 tail", int'(smp_code), exp);
                    else if (disturb && dd) chk(int'(smp_code) == exp, "R1 busy start", int'(smp_code), exp);
                    else chk(int'(smp_code) == exp, rq, int'(smp_code), exp);
                    idx++;
                end else begin
                    have_hold = 1; held = int'(smp_code);
                end
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(idx == total, "R3 count", idx, total);
        chk(seq_done && !smp_valid, "R10 done", {30'd0, seq_done, smp_valid}, 2);
        exp = model(shp, lo, hi, ns, ph0, fw, ns - 1);
        repeat (3) @(negedge clk);
        chk(int'(smp_code) == exp && !smp_valid, "R10 hold", int'(smp_code), exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "R3 watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lens[8];
        int los[4];
        int his[4];
        int run;
        lens = '{1, 2, 3, 4, 5, 8, 9, 17};
        los  = '{0, 7, 100, 0};
        his  = '{0, 10, 3000, 4095};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(!smp_valid && !seq_done && smp_code == '0, "R11 reset", int'(smp_code), 0);
        run = 0;
        for (int sh = 0; sh < 4; sh++) begin
            for (int li = 0; li < 8; li++) begin
                for (int si = 0; si < 4; si++) begin
                    run_case(sh, los[si], his[si], lens[li], (run % 3), (run % 4) / 2 * 3,
                             (run * 12345) & 16'hFFFF, 16'h0800 + run * 16'h0137,
                             (run % 2) == 1, 1'b0);
                    run++;
                end
            end
        end
        // R8: fine phase steps crossing every quadrant
        run_case(0, 0, 4095, 17, 0, 0, 16'hC000, 16'h1000, 1'b0, 1'b0);
        run_case(0, 50, 2050, 9, 1, 1, 16'h3E00, 16'h2000, 1'b1, 1'b0);
        // R1: start and setting changes during a running sequence
        run_case(1, 0, 4095, 9, 2, 2, 0, 0, 1'b0, 1'b1);
        run_case(3, 10, 900, 8, 1, 1, 0, 0, 1'b1, 1'b1);
        run_case(0, 0, 4095, 8, 2, 1, 16'h1111, 16'h0E00, 1'b0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule